// File: doc/BRIEF.md
# Dual-Rail Four-Phase Channel Link

This block is a matched transmitter and receiver that carry an N-bit word across a delay-insensitive channel. Each data bit travels on a pair of rails, and a single acknowledge wire runs back from the receiver. No request wire is used: the receiver finds out that a word has arrived by checking the rails themselves. Each transfer runs as a four-phase cycle, and every transfer returns all rails to the empty spacer code before the next word may start.

The transmitter takes words from a valid/ready input port and drives their rail codes. The receiver samples the rails and classifies every bit as valid, spacer or illegal. It merges per-bit completion through a two-level tree of set/reset C-elements. Once the tree reports that every bit holds data, the receiver captures the word into its output register, raises acknowledge on the next cycle, and waits for an all-spacer channel before it lowers acknowledge. Captured words leave on a valid/ready output port.

The channel wires are brought out as ports, so the two ends can be joined directly or through any path with skew, and every wire is modelled as clocked sampled logic. A sticky flag records any rail pair seen at the forbidden code.

Top module: `dr_link_top`

## Requirements
- R1: A bit of value 0 is sent as (hi,lo) = (0,1) and a bit of value 1 as (1,0). The transmitter drives the code of a word on the first clock edge after that word is accepted on the input port.
- R2: After reset, all transmit rails are (0,0), acknowledge is low, out_valid is low, proto_err is low and in_ready is high.
- R3: The receiver does not capture a word while any bit position lacks a valid code, however long it waits. Its completion C-elements set only when all their inputs are 1, clear only when all are 0, and otherwise hold.
- R4: When the last bit becomes valid on the receive rails, out_valid rises four clock edges later with the word on out_data. rx_ack rises one edge after that, and never before the capture.
- R5: Two edges after tx_ack goes high, the transmitter returns every rail to (0,0).
- R6: While any receive bit still holds data, rx_ack stays high. Four edges after the last bit returns to (0,0), rx_ack falls.
- R7: in_ready stays low while tx_ack is high, and rises two edges after tx_ack falls following the spacer phase.
- R8: A receive rail pair at (1,1) is not counted as valid. It sets proto_err two edges after it appears, and proto_err stays set until reset.
- R9: While out_valid is high and out_ready is low, out_data holds its value, no new word is captured and no acknowledge is raised for a waiting word.
- R10: With the two ends joined through a channel whose bits arrive at random times, every word leaves the output port once, in order and unchanged. This includes the all-zero and all-one words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word offered |
| in_data | input | N | Input word |
| in_ready | output | 1 | Transmitter can accept a word |
| tx_hi | output | N | Transmit rails, true side |
| tx_lo | output | N | Transmit rails, false side |
| tx_ack | input | 1 | Acknowledge as seen by the transmitter |
| rx_hi | input | N | Receive rails, true side |
| rx_lo | input | N | Receive rails, false side |
| rx_ack | output | 1 | Acknowledge driven by the receiver |
| out_valid | output | 1 | Captured word available |
| out_data | output | N | Captured word |
| out_ready | input | 1 | Consumer takes the word |
| proto_err | output | 1 | Sticky flag for a (1,1) rail pair |

## Verification
Each result has a fixed number of edges between stimulus and effect. Rail codes appear one edge after acceptance. Spacer on the transmit side follows two edges after tx_ack rises, and in_ready two edges after it falls. The capture lands four edges after the last receive bit completes, with acknowledge one edge later. Acknowledge falls four edges after the last bit returns to spacer. The directed checks drive inputs at the falling edge and sample at the falling edge exactly that many edges later. Where a result must not appear at all, they sample well beyond that latency. The random part joins the ends through per-bit random skew and random output back-pressure. It compares each delivered word against a queue filled at acceptance, so the result does not depend on how many cycles each word takes.

// File: rtl/dr_link_pkg.sv
package dr_link_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_DRIVE = 2'd1,
    TX_RTZ   = 2'd2
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_WAIT   = 2'd0,
    RX_STORED = 2'd1,
    RX_ACK    = 2'd2
  } rx_state_e;
endpackage

// File: rtl/dr_celem.sv
module dr_celem #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_vec,
  output logic         q
);
  logic q_n;

  always_comb begin
    q_n = q;
    if (&in_vec)       q_n = 1'b1;
    else if (~|in_vec) q_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_n;
  end

  // R3: set only on all-ones, hold on mixed inputs
  assert_celem_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (&in_vec) |=> q) else $error("celem did not set");
  assert_celem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&in_vec) && (|in_vec)) |=> $stable(q)) else $error("celem did not hold");
endmodule

// File: rtl/dr_rail_check.sv
module dr_rail_check #(
  parameter int N = 16
) (
  input  logic [N-1:0] hi,
  input  logic [N-1:0] lo,
  output logic [N-1:0] valid_vec,
  output logic         all_spacer,
  output logic         illegal_any
);
  logic [N-1:0] spacer_vec;
  logic [N-1:0] illegal_vec;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign valid_vec[i]   = hi[i] ^ lo[i];
    assign spacer_vec[i]  = ~hi[i] & ~lo[i];
    assign illegal_vec[i] = hi[i] & lo[i];
  end

  assign all_spacer  = &spacer_vec;
  assign illegal_any = |illegal_vec;
endmodule

// File: rtl/dr_completion.sv
module dr_completion #(
  parameter int N   = 16,
  parameter int GRP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] valid_vec,
  output logic         done
);
  localparam int NGRP = (N + GRP - 1) / GRP;

  logic [NGRP-1:0] leaf_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_leaf
    logic [GRP-1:0] grp_in;
    for (genvar k = 0; k < GRP; k++) begin : g_in
      if (g * GRP + k < N) begin : g_real
        assign grp_in[k] = valid_vec[g*GRP+k];
      end else begin : g_pad
        assign grp_in[k] = valid_vec[g*GRP];
      end
    end
    dr_celem #(.W(GRP)) u_leaf (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_vec (grp_in),
      .q      (leaf_q[g])
    );
  end

  dr_celem #(.W(NGRP)) u_root (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vec (leaf_q),
    .q      (done)
  );
endmodule

// File: rtl/dr_sender.sv
module dr_sender
  import dr_link_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [N-1:0] in_data,
  output logic         in_ready,
  output logic [N-1:0] tx_hi,
  output logic [N-1:0] tx_lo,
  input  logic         tx_ack
);
  tx_state_e    state, state_n;
  logic [N-1:0] hi_n, lo_n;
  logic         ack_s;

  always_comb begin
    state_n = state;
    hi_n    = tx_hi;
    lo_n    = tx_lo;
    case (state)
      TX_IDLE: if (in_valid && !ack_s) begin
        hi_n    = in_data;
        lo_n    = ~in_data;
        state_n = TX_DRIVE;
      end
      TX_DRIVE: if (ack_s) begin
        hi_n    = '0;
        lo_n    = '0;
        state_n = TX_RTZ;
      end
      TX_RTZ: if (!ack_s) state_n = TX_IDLE;
      default: state_n = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      tx_hi <= '0;
      tx_lo <= '0;
      ack_s <= 1'b0;
    end else begin
      state <= state_n;
      tx_hi <= hi_n;
      tx_lo <= lo_n;
      ack_s <= tx_ack;
    end
  end

  assign in_ready = (state == TX_IDLE) && !ack_s;

  assert_no_both_rails_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_hi & tx_lo) == '0) else $error("illegal rail pair driven");
  assert_rtz_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_DRIVE && ack_s) |=> (tx_hi == '0 && tx_lo == '0))
    else $error("rails not returned to spacer");
  assert_start_after_ack_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_hi | tx_lo) != '0 && $past((tx_hi | tx_lo) == '0)) |-> !$past(ack_s))
    else $error("word started while acknowledge high");
endmodule

// File: rtl/dr_receiver.sv
module dr_receiver
  import dr_link_pkg::*;
#(
  parameter int N   = 16,
  parameter int GRP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rx_hi,
  input  logic [N-1:0] rx_lo,
  output logic         rx_ack,
  output logic         out_valid,
  output logic [N-1:0] out_data,
  input  logic         out_ready,
  output logic         proto_err
);
  rx_state_e    state, state_n;
  logic [N-1:0] r_hi, r_lo;
  logic [N-1:0] valid_vec;
  logic         all_spacer, illegal_any, comp;
  logic [N-1:0] data_n;
  logic         ov_n, ack_n, err_n;

  dr_rail_check #(.N(N)) u_check (
    .hi          (r_hi),
    .lo          (r_lo),
    .valid_vec   (valid_vec),
    .all_spacer  (all_spacer),
    .illegal_any (illegal_any)
  );

  dr_completion #(.N(N), .GRP(GRP)) u_comp (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .done      (comp)
  );

  always_comb begin
    state_n = state;
    data_n  = out_data;
    ov_n    = out_valid && !out_ready;
    ack_n   = rx_ack;
    err_n   = proto_err | illegal_any;
    case (state)
      RX_WAIT: if (comp && !out_valid) begin
        data_n  = r_hi;
        ov_n    = 1'b1;
        state_n = RX_STORED;
      end
      RX_STORED: begin
        ack_n   = 1'b1;
        state_n = RX_ACK;
      end
      RX_ACK: if (!comp && all_spacer) begin
        ack_n   = 1'b0;
        state_n = RX_WAIT;
      end
      default: state_n = RX_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_WAIT;
      r_hi      <= '0;
      r_lo      <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      rx_ack    <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      state     <= state_n;
      r_hi      <= rx_hi;
      r_lo      <= rx_lo;
      out_data  <= data_n;
      out_valid <= ov_n;
      rx_ack    <= ack_n;
      proto_err <= err_n;
    end
  end

  assert_store_needs_complete_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(comp)) else $error("capture without completion");
  assert_ack_after_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ack) |-> $past(out_valid)) else $error("ack before store");
  assert_ack_drop_spacer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ack) |-> ($past(all_spacer) && !$past(comp)))
    else $error("ack dropped before spacer");
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err) else $error("error flag cleared");
  assert_hold_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
    else $error("output not held");
endmodule

// File: rtl/dr_link_top.sv
module dr_link_top #(
  parameter int N   = 16,
  parameter int GRP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [N-1:0] in_data,
  output logic         in_ready,
  output logic [N-1:0] tx_hi,
  output logic [N-1:0] tx_lo,
  input  logic         tx_ack,
  input  logic [N-1:0] rx_hi,
  input  logic [N-1:0] rx_lo,
  output logic         rx_ack,
  output logic         out_valid,
  output logic [N-1:0] out_data,
  input  logic         out_ready,
  output logic         proto_err
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  dr_sender #(.N(N)) u_tx (
    .clk      (clk),
    .rst_n    (rst_sync),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .tx_hi    (tx_hi),
    .tx_lo    (tx_lo),
    .tx_ack   (tx_ack)
  );

  dr_receiver #(.N(N), .GRP(GRP)) u_rx (
    .clk       (clk),
    .rst_n     (rst_sync),
    .rx_hi     (rx_hi),
    .rx_lo     (rx_lo),
    .rx_ack    (rx_ack),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .proto_err (proto_err)
  );
endmodule

// File: tb/dr_link_tb.sv
module dr_link_top_tb_top;
  localparam int N    = 16;
  localparam int NUM  = 300;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, tx_ack, out_ready;
  logic [N-1:0] in_data, rx_hi, rx_lo;
  logic         in_ready, rx_ack, out_valid, proto_err;
  logic [N-1:0] tx_hi, tx_lo, out_data;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dr_link_top #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tx_hi(tx_hi), .tx_lo(tx_lo), .tx_ack(tx_ack),
    .rx_hi(rx_hi), .rx_lo(rx_lo), .rx_ack(rx_ack), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .proto_err(proto_err)
  );

  function automatic logic [N-1:0] code_hi(input logic [N-1:0] w);
    return w;
  endfunction
  function automatic logic [N-1:0] code_lo(input logic [N-1:0] w);
    return ~w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(3);
  endtask

  logic [N-1:0] expq [NUM];

  initial begin
    logic [N-1:0] w;
    int sent, rcvd;
    bit acc;
    void'($urandom(32'd20240611));
    in_valid = 0; in_data = '0; tx_ack = 0; out_ready = 0;
    rx_hi = '0; rx_lo = '0;
    do_reset();

    // R2 reset state
    chk("R2 tx_hi", tx_hi, 0);
    chk("R2 tx_lo", tx_lo, 0);
    chk("R2 rx_ack", rx_ack, 0);
    chk("R2 out_valid", out_valid, 0);
    chk("R2 proto_err", proto_err, 0);
    chk("R2 in_ready", in_ready, 1);

    // R1 encoding, transmitter side on its own
    w = 16'hA5C3;
    in_valid = 1; in_data = w;
    tick(1);
    in_valid = 0;
    chk("R1 hi rails", tx_hi, code_hi(w));
    chk("R1 lo rails", tx_lo, code_lo(w));
    chk("R7 busy in_ready", in_ready, 0);
    // R5 return to spacer
    tx_ack = 1;
    tick(1);
    chk("R5 rails held one edge", tx_hi, code_hi(w));
    tick(1);
    chk("R5 hi spacer", tx_hi, 0);
    chk("R5 lo spacer", tx_lo, 0);
    // R7 wait for ack low
    tick(3);
    chk("R7 in_ready ack high", in_ready, 0);
    tx_ack = 0;
    tick(1);
    chk("R7 in_ready one edge", in_ready, 0);
    tick(1);
    chk("R7 in_ready two edges", in_ready, 1);
    w = 16'h0001;
    in_valid = 1; in_data = w;
    tick(1);
    in_valid = 0;
    chk("R1 second word hi", tx_hi, code_hi(w));
    chk("R1 second word lo", tx_lo, code_lo(w));
    tx_ack = 1; tick(2); tx_ack = 0; tick(2);

    // R3 partial word never captured
    w = 16'h3C5A;
    rx_hi = code_hi(w); rx_lo = code_lo(w);
    rx_hi[5] = 0; rx_lo[5] = 0;
    tick(10);
    chk("R3 no capture partial", out_valid, 0);
    chk("R3 no ack partial", rx_ack, 0);
    rx_hi[5] = w[5]; rx_lo[5] = ~w[5];
    tick(3);
    chk("R4 not yet captured", out_valid, 0);
    tick(1);
    chk("R4 captured", out_valid, 1);
    chk("R4 data", out_data, w);
    chk("R4 ack after store", rx_ack, 0);
    tick(1);
    chk("R4 ack raised", rx_ack, 1);
    // R6 ack held until last bit returns
    rx_hi = '0; rx_lo = '0;
    rx_hi[9] = w[9]; rx_lo[9] = ~w[9];
    tick(10);
    chk("R6 ack held", rx_ack, 1);
    chk("R9 out_valid held", out_valid, 1);
    chk("R9 out_data held", out_data, w);
    rx_hi[9] = 0; rx_lo[9] = 0;
    tick(3);
    chk("R6 ack three edges", rx_ack, 1);
    tick(1);
    chk("R6 ack dropped", rx_ack, 0);
    // R9 second word waits behind held output
    rx_hi = code_hi(16'hFFFF); rx_lo = code_lo(16'hFFFF);
    tick(10);
    chk("R9 no overwrite", out_data, w);
    chk("R9 no ack while blocked", rx_ack, 0);
    out_ready = 1;
    tick(1);
    out_ready = 0;
    chk("R9 popped", out_valid, 0);
    tick(1);
    chk("R9 next captured", out_valid, 1);
    chk("R9 next data", out_data, 16'hFFFF);
    tick(1);
    chk("R4 ack second", rx_ack, 1);
    rx_hi = '0; rx_lo = '0;
    tick(4);
    chk("R6 ack second drop", rx_ack, 0);
    out_ready = 1; tick(1); out_ready = 0;

    // R8 illegal code
    w = 16'h1234;
    rx_hi = code_hi(w); rx_lo = code_lo(w);
    rx_hi[3] = 1; rx_lo[3] = 1;
    tick(1);
    chk("R8 err not yet", proto_err, 0);
    tick(1);
    chk("R8 err set", proto_err, 1);
    tick(8);
    chk("R8 illegal bit not valid", out_valid, 0);
    rx_hi = '0; rx_lo = '0;
    tick(6);
    chk("R8 err sticky", proto_err, 1);
    chk("R8 no ack", rx_ack, 0);
    do_reset();
    chk("R2 err cleared by reset", proto_err, 0);

    // R10 random loopback with skew and back-pressure
    sent = 0; rcvd = 0; acc = 0;
    for (int cyc = 0; cyc < 60000 && rcvd < NUM; cyc++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(0, 1) == 1) begin
          rx_hi[i] = tx_hi[i];
          rx_lo[i] = tx_lo[i];
        end
      end
      tx_ack = rx_ack;
      if (acc) begin in_valid = 0; acc = 0; end
      if (!in_valid && sent < NUM && $urandom_range(0, 3) != 0) begin
        in_data  = (sent == 0) ? '0 : (sent == 1) ? '1 : N'($urandom);
        in_valid = 1;
      end
      if (in_valid && in_ready) begin
        expq[sent] = in_data;
        sent++;
        acc = 1;
      end
      out_ready = ($urandom_range(0, 2) != 0);
      if (out_valid && out_ready) begin
        chk("R10 word order", out_data, expq[rcvd]);
        rcvd++;
      end
    end
    chk("R10 all words delivered", rcvd, NUM);
    chk("R10 no error flag", proto_err, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule